// File: doc/BRIEF.md
# Control-Word Register ALU Datapath

This block is an 8-bit execution datapath. It has seven general registers, an external input bus, two source multiplexers, an arithmetic-logic unit and a destination decoder. A sequencer outside the block presents one 14-bit control word each clock. The word chooses the two sources, the operation and the register that receives the result. The ALU result always appears on the output bus within the same cycle. If a destination is named, the result is written into that register on the next rising clock edge.

A four-bit status register records the carry, sign, zero and overflow conditions of each legal operation at the same edge. Software sees no registers here. The register contents can be observed only by moving a register to the output bus with a transfer operation. Fetch, sequencing and memory are outside this block.

Top module: `ctlword_datapath`

## Requirements
- R1: A synchronous reset, active high on `rst`, clears all seven registers and all four flags at the clock edge.
- R2: The control word fields, from bit 13 down, are: source A select [13:11], source B select [10:8], destination select [7:5] and operation code [4:0].
- R3: Source select code 0 routes `inBus` to that ALU operand. Codes 1 to 7 route register R1 to R7.
- R4: Destination code 0 writes no register. Destination code n (1 to 7) loads Rn with the ALU result at the rising edge, and no other register changes.
- R5: `outBus` carries the ALU result combinationally in every cycle, whatever the destination code.
- R6: Arithmetic operations work modulo 256: 00001 gives A+1, 00010 gives A+B, 00101 gives A-B and 00110 gives A-1.
- R7: Transfer and logic operations: 00000 gives A, 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B and 01110 gives NOT A.
- R8: Shift operations: 10000 shifts A right by one with a zero fill, and the carry takes A bit 0. 11000 shifts A left by one with a zero fill, and the carry takes A bit 7.
- R9: On every legal operation the flags load at the edge. Sign is result bit 7. Zero is set when the result is 0. For the four arithmetic operations, carry is the carry out of bit 7 of A+B, A+(NOT B)+1, A+1 or A+0xFF, and overflow is the carry into bit 7 XOR the carry out of bit 7. Transfer and logic operations clear carry and overflow. Shifts clear overflow.
- R10: Any other operation code drives `outBus` to 0, writes no register and leaves all flags unchanged.
- R11: An XOR of a register with itself, written back to the same register, clears that register and sets the zero flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ctrlWord | input | 14 | Control word: source A, source B, destination, operation |
| inBus | input | 8 | External operand, selected by source code 0 |
| outBus | output | 8 | ALU result of the current cycle |
| carryFlag | output | 1 | Registered carry flag |
| signFlag | output | 1 | Registered sign flag |
| zeroFlag | output | 1 | Registered zero flag |
| overflowFlag | output | 1 | Registered signed overflow flag |

## Verification
Some checks need only the ports, so the assertions make them on every cycle. These are: sign and zero match the previous result, flags hold under an illegal code, the output is zero under an illegal code, transfer and logic clear carry and overflow, and the shift carry is the shifted-out bit whenever the input bus is the source. Register contents cannot be seen at the ports, so the bench checks them. It keeps its own model of the seven registers and reads them back through transfers. That model is what shows that a destination code of zero or an illegal code leaves the registers untouched. Overflow and carry values for arithmetic on register operands are also checked only in the bench.

// File: rtl/ctlword_pkg.sv
package ctlword_pkg;

  localparam int SEL_W    = 3;
  localparam int OP_W     = 5;
  localparam int CW_W     = 3 * SEL_W + OP_W;
  localparam int NUM_SRC  = 1 << SEL_W;
  localparam int NUM_REGS = NUM_SRC - 1;

  typedef enum logic [OP_W-1:0] {
    OP_PASS = 5'b00000,
    OP_INC  = 5'b00001,
    OP_ADD  = 5'b00010,
    OP_SUB  = 5'b00101,
    OP_DEC  = 5'b00110,
    OP_AND  = 5'b01000,
    OP_OR   = 5'b01010,
    OP_XOR  = 5'b01100,
    OP_NOT  = 5'b01110,
    OP_SHR  = 5'b10000,
    OP_SHL  = 5'b11000
  } aluOpE;

  // strobes from control to datapath
  typedef struct packed {
    logic [SEL_W-1:0]    selA;
    logic [SEL_W-1:0]    selB;
    logic [NUM_REGS-1:0] loadMask;
    aluOpE               op;
    logic                flagLoad;
  } ctrlStrobeT;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } flagsT;

endpackage

// File: rtl/cw_control.sv
module cw_control
  import ctlword_pkg::*;
(
  input  logic [CW_W-1:0] ctrlWord,
  output ctrlStrobeT      strobes
);

  logic [SEL_W-1:0] fieldA;
  logic [SEL_W-1:0] fieldB;
  logic [SEL_W-1:0] fieldD;
  logic [OP_W-1:0]  fieldOp;
  logic             opLegal;
  logic [NUM_SRC-1:0] destDecode;

  assign {fieldA, fieldB, fieldD, fieldOp} = ctrlWord;

  always_comb begin
    case (fieldOp)
      OP_PASS, OP_INC, OP_ADD, OP_SUB, OP_DEC,
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_SHR, OP_SHL: opLegal = 1'b1;
      default:                                       opLegal = 1'b0;
    endcase
  end

  // 3-to-8 destination decoder; output 0 is the "no write" code
  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : gDec
      assign destDecode[g] = (fieldD == SEL_W'(g));
    end
  endgenerate

  always_comb begin
    strobes.selA     = fieldA;
    strobes.selB     = fieldB;
    strobes.loadMask = destDecode[NUM_SRC-1:1] & {NUM_REGS{opLegal}};
    strobes.op       = aluOpE'(fieldOp);
    strobes.flagLoad = opLegal;
  end

endmodule

// File: rtl/cw_alu.sv
module cw_alu
  import ctlword_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluOpE             op,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output flagsT             flagsNext
);

  logic [DATA_W-1:0] addX;
  logic [DATA_W-1:0] addY;
  logic              addCin;
  logic              useAdder;
  logic [DATA_W:0]   sumFull;
  logic [DATA_W-1:0] sumLow;
  logic              carryOut;
  logic              overflow;

  // operand steering for the shared adder
  always_comb begin
    addX     = opA;
    addY     = '0;
    addCin   = 1'b0;
    useAdder = 1'b0;
    case (op)
      OP_INC: begin addCin = 1'b1; useAdder = 1'b1; end
      OP_ADD: begin addY = opB; useAdder = 1'b1; end
      OP_SUB: begin addY = ~opB; addCin = 1'b1; useAdder = 1'b1; end
      OP_DEC: begin addY = '1; useAdder = 1'b1; end
      default: ;
    endcase
  end

  assign sumFull = {1'b0, addX} + {1'b0, addY} + {{DATA_W{1'b0}}, addCin};
  assign sumLow  = {1'b0, addX[DATA_W-2:0]} + {1'b0, addY[DATA_W-2:0]}
                 + {{(DATA_W-1){1'b0}}, addCin};

  always_comb begin
    result   = '0;
    carryOut = 1'b0;
    overflow = 1'b0;
    if (useAdder) begin
      result   = sumFull[DATA_W-1:0];
      carryOut = sumFull[DATA_W];
      overflow = sumFull[DATA_W] ^ sumLow[DATA_W-1];
    end else begin
      case (op)
        OP_PASS: result = opA;
        OP_AND:  result = opA & opB;
        OP_OR:   result = opA | opB;
        OP_XOR:  result = opA ^ opB;
        OP_NOT:  result = ~opA;
        OP_SHR: begin
          result   = {1'b0, opA[DATA_W-1:1]};
          carryOut = opA[0];
        end
        OP_SHL: begin
          result   = {opA[DATA_W-2:0], 1'b0};
          carryOut = opA[DATA_W-1];
        end
        default: result = '0;
      endcase
    end
  end

  assign flagsNext.c = carryOut;
  assign flagsNext.s = result[DATA_W-1];
  assign flagsNext.z = (result == '0);
  assign flagsNext.v = overflow;

endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
  import ctlword_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobeT        strobes,
  input  logic [DATA_W-1:0] inBus,
  output logic [DATA_W-1:0] outBus,
  output flagsT             flagsQ
);

  logic [DATA_W-1:0] srcTable [0:NUM_REGS];
  logic [DATA_W-1:0] busA;
  logic [DATA_W-1:0] busB;
  logic [DATA_W-1:0] aluResult;
  flagsT             aluFlags;

  assign srcTable[0] = inBus;

  genvar g;
  generate
    for (g = 1; g <= NUM_REGS; g++) begin : gReg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                        q <= '0;
        else if (strobes.loadMask[g-1]) q <= aluResult;
      end
      assign srcTable[g] = q;
    end
  endgenerate

  assign busA = srcTable[strobes.selA];
  assign busB = srcTable[strobes.selB];

  cw_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (strobes.op),
    .opA      (busA),
    .opB      (busB),
    .result   (aluResult),
    .flagsNext(aluFlags)
  );

  assign outBus = aluResult;

  always_ff @(posedge clk) begin
    if (rst)                   flagsQ <= '0;
    else if (strobes.flagLoad) flagsQ <= aluFlags;
  end

endmodule

// File: rtl/ctlword_datapath.sv
module ctlword_datapath
  import ctlword_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW_W-1:0]   ctrlWord,
  input  logic [DATA_W-1:0] inBus,
  output logic [DATA_W-1:0] outBus,
  output logic              carryFlag,
  output logic              signFlag,
  output logic              zeroFlag,
  output logic              overflowFlag
);

  ctrlStrobeT strobes;
  flagsT      flagsQ;

  cw_control u_ctrl (
    .ctrlWord(ctrlWord),
    .strobes (strobes)
  );

  cw_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .inBus  (inBus),
    .outBus (outBus),
    .flagsQ (flagsQ)
  );

  assign carryFlag    = flagsQ.c;
  assign signFlag     = flagsQ.s;
  assign zeroFlag     = flagsQ.z;
  assign overflowFlag = flagsQ.v;

endmodule

// File: rtl/cw_checker.sv
module cw_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [13:0]       ctrlWord,
  input logic [DATA_W-1:0] inBus,
  input logic [DATA_W-1:0] outBus,
  input logic              carryFlag,
  input logic              signFlag,
  input logic              zeroFlag,
  input logic              overflowFlag
);

  logic [4:0] opc;
  logic       legal;
  logic       plainLogic;
  logic       fromInput;

  assign opc       = ctrlWord[4:0];
  assign fromInput = (ctrlWord[13:11] == 3'd0);

  always_comb begin
    legal      = 1'b0;
    plainLogic = 1'b0;
    case (opc)
      5'b00000, 5'b01000, 5'b01010, 5'b01100, 5'b01110: begin
        legal = 1'b1; plainLogic = 1'b1;
      end
      5'b00001, 5'b00010, 5'b00101, 5'b00110, 5'b10000, 5'b11000: legal = 1'b1;
      default: ;
    endcase
  end

  // R1: flags read zero after a reset edge
  p_reset_flags_r1: assert property (@(posedge clk)
    rst |=> !carryFlag && !signFlag && !zeroFlag && !overflowFlag);

  // R10: illegal code drives zero on the output bus
  p_illegal_zero_out_r10: assert property (@(posedge clk) disable iff (rst)
    !legal |-> outBus == '0);

  // R10: illegal code holds every flag
  p_illegal_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !legal |=> $stable({carryFlag, signFlag, zeroFlag, overflowFlag}));

  // R9: zero flag follows previous result
  p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
    legal |=> zeroFlag == ($past(outBus) == '0));

  // R9: sign flag follows previous result MSB
  p_sign_flag_r9: assert property (@(posedge clk) disable iff (rst)
    legal |=> signFlag == $past(outBus[DATA_W-1]));

  // R9: transfer and logic clear carry and overflow
  p_logic_clears_cv_r9: assert property (@(posedge clk) disable iff (rst)
    plainLogic |=> !carryFlag && !overflowFlag);

  // R8: right shift of input bus, carry gets bit 0
  p_shr_carry_r8: assert property (@(posedge clk) disable iff (rst)
    (opc == 5'b10000 && fromInput) |=> carryFlag == $past(inBus[0]) && !overflowFlag);

  // R8: left shift of input bus, carry gets MSB
  p_shl_carry_r8: assert property (@(posedge clk) disable iff (rst)
    (opc == 5'b11000 && fromInput) |=> carryFlag == $past(inBus[DATA_W-1]) && !overflowFlag);

endmodule

bind ctlword_datapath cw_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_ctlword_datapath.sv
`timescale 1ns/1ps
module sim_ctlword_datapath;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] ctrlWord = '0;
  logic [7:0]  inBus = '0;
  logic [7:0]  outBus;
  logic        carryFlag, signFlag, zeroFlag, overflowFlag;

  int checks = 0;
  int errors = 0;
  logic [7:0] mReg [1:7];
  logic mC = 0, mS = 0, mZ = 0, mV = 0;

  always #4 clk = ~clk;

  ctlword_datapath u0 (
    .clk(clk), .rst(rst), .ctrlWord(ctrlWord), .inBus(inBus), .outBus(outBus),
    .carryFlag(carryFlag), .signFlag(signFlag), .zeroFlag(zeroFlag),
    .overflowFlag(overflowFlag)
  );

  function automatic logic [13:0] mk(input logic [2:0] a, input logic [2:0] b,
                                     input logic [2:0] d, input logic [4:0] op);
    return {a, b, d, op};
  endfunction

  // returns {legal, carry, overflow, result[7:0]}
  function automatic logic [10:0] refAlu(input logic [4:0] op, input logic [7:0] a,
                                         input logic [7:0] b);
    logic [7:0] r; logic c; logic v; logic ok;
    r = 0; c = 0; v = 0; ok = 1;
    case (op)
      5'b00000: r = a;
      5'b00001: begin r = a + 8'd1; c = (a == 8'hFF); v = (a == 8'h7F); end
      5'b00010: begin r = a + b; c = (int'(a) + int'(b)) > 255;
                      v = (a[7] == b[7]) && (r[7] != a[7]); end
      5'b00101: begin r = a - b; c = (a >= b);
                      v = (a[7] != b[7]) && (r[7] != a[7]); end
      5'b00110: begin r = a - 8'd1; c = (a != 0); v = (a == 8'h80); end
      5'b01000: r = a & b;
      5'b01010: r = a | b;
      5'b01100: r = a ^ b;
      5'b01110: r = ~a;
      5'b10000: begin r = a >> 1; c = a[0]; end
      5'b11000: begin r = a << 1; c = a[7]; end
      default:  ok = 0;
    endcase
    return {ok, c, v, r};
  endfunction

  function automatic string opTag(input logic [4:0] op);
    case (op)
      5'b00001, 5'b00010, 5'b00101, 5'b00110: return "R6";
      5'b10000, 5'b11000:                     return "R8";
      5'b00000, 5'b01000, 5'b01010, 5'b01100, 5'b01110: return "R7";
      default:                                return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [13:0] w, input logic [7:0] d, input string tag);
    logic [7:0] a, b; logic [10:0] r;
    @(negedge clk);
    ctrlWord = w; inBus = d;
    #1;
    a = (w[13:11] == 0) ? d : mReg[w[13:11]];
    b = (w[10:8]  == 0) ? d : mReg[w[10:8]];
    r = refAlu(w[4:0], a, b);
    check(tag, outBus, r[7:0]);
    @(posedge clk); #1;
    if (r[10]) begin
      mC = r[9]; mV = r[8]; mS = r[7]; mZ = (r[7:0] == 0);
      if (w[7:5] != 0) mReg[w[7:5]] = r[7:0];
    end
    check(r[10] ? "R9" : "R10", {carryFlag, signFlag, zeroFlag, overflowFlag},
          {mC, mS, mZ, mV});
  endtask

  task automatic readBack(input logic [2:0] n, input string tag);
    step(mk(n, 3'd0, 3'd0, 5'b00000), 8'h00, tag);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 1; i <= 7; i++) mReg[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {carryFlag, signFlag, zeroFlag, overflowFlag}, 4'b0000);
    @(negedge clk); rst = 1'b0;
    for (int i = 1; i <= 7; i++) readBack(3'(i), "R1");

    // R3: input bus as source A and B
    step(mk(3'd0, 3'd0, 3'd0, 5'b00000), 8'hA5, "R3");
    step(mk(3'd0, 3'd0, 3'd0, 5'b01100), 8'h3C, "R3");
    // R4: load registers
    step(mk(3'd0, 3'd0, 3'd1, 5'b00000), 8'h7F, "R4");
    step(mk(3'd0, 3'd0, 3'd3, 5'b00000), 8'h5A, "R4");
    step(mk(3'd0, 3'd0, 3'd7, 5'b00000), 8'h05, "R4");
    readBack(3'd1, "R4"); readBack(3'd3, "R4"); readBack(3'd7, "R4");
    // R2: field order distinguishes A-B from B-A
    step(mk(3'd3, 3'd7, 3'd2, 5'b00101), 8'h00, "R2");
    readBack(3'd2, "R2");
    // R5: no destination still shows the result
    step(mk(3'd3, 3'd0, 3'd0, 5'b00001), 8'h00, "R5");
    readBack(3'd3, "R4");
    // R9: overflow and carry corners
    step(mk(3'd1, 3'd0, 3'd0, 5'b00010), 8'h01, "R9");
    step(mk(3'd0, 3'd0, 3'd0, 5'b00001), 8'hFF, "R9");
    step(mk(3'd7, 3'd0, 3'd0, 5'b00101), 8'h05, "R9");
    step(mk(3'd0, 3'd0, 3'd0, 5'b00110), 8'h80, "R9");
    step(mk(3'd0, 3'd0, 3'd0, 5'b00110), 8'h00, "R9");
    // R8: shifts with bits leaving
    step(mk(3'd0, 3'd0, 3'd4, 5'b10000), 8'h81, "R8");
    step(mk(3'd0, 3'd0, 3'd5, 5'b11000), 8'h81, "R8");
    readBack(3'd4, "R8"); readBack(3'd5, "R8");
    // R10: illegal code, flags held after a flag-setting op
    step(mk(3'd0, 3'd0, 3'd0, 5'b00001), 8'h7F, "R9");
    step(mk(3'd3, 3'd3, 3'd3, 5'b00011), 8'h11, "R10");
    readBack(3'd3, "R10");
    // R11: self XOR clears
    step(mk(3'd3, 3'd3, 3'd3, 5'b01100), 8'h00, "R11");
    check("R11", zeroFlag, 1'b1);
    readBack(3'd3, "R11");

    void'($urandom(32'h00C0FFEE));
    for (int k = 0; k < 600; k++) begin
      logic [4:0] op;
      logic [10:0] probe;
      op = 5'($urandom_range(0, 31));
      probe = refAlu(op, 8'h00, 8'h00);
      if (!probe[10] && ($urandom_range(0, 3) != 0))
        op = 5'b01100;
      step(mk(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
              3'($urandom_range(0, 7)), op), 8'($urandom_range(0, 255)), opTag(op));
    end
    for (int i = 1; i <= 7; i++) readBack(3'(i), "R4");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule